// File: doc/BRIEF.md
# USB Device IN Transaction Responder

This block is the device-side decision logic that answers IN tokens coming from a USB host. A packet receiver hands it one decoded token per pulse: a PID byte, a 7-bit device address and a 4-bit endpoint number. The block decides whether to stay silent, ask the packet transmitter for a NAK handshake, or ask it to send the endpoint's buffer as a data packet. After a data packet on a non-isochronous endpoint, it waits a bounded number of full-speed bit times for the host's ACK. It then records the outcome for the local microprocessor.

The microprocessor sees a per-endpoint buffer-full flag that it raises after it refills a buffer. It also sees a sticky per-endpoint interrupt vector with a combined request line, and a two-bit outcome code per endpoint. Interrupt bits are cleared by writing ones. An outcome code clears when it is read. The endpoint enable and endpoint type vectors come from surrounding configuration logic.

Top module: `in_xact_engine`

## Requirements
- R1: After reset, all buffer-full flags, interrupt bits and outcome codes are zero, the request line is low, and neither transmit request is asserted.
- R2: A token is acted on only when all of the following hold: its PID byte has an upper nibble equal to the bitwise complement of its lower nibble, the lower nibble is 1001 (IN, so the byte is 0x69), the address equals `devAddr`, and the endpoint's `epEnable` bit is 1. Any other token produces no transmit request.
- R3: An accepted token for an endpoint whose buffer-full flag is 1 raises `txDataReq` for exactly one cycle, in the cycle after the token, with `txEp` equal to the token's endpoint.
- R4: An accepted token for an endpoint whose buffer-full flag is 0 raises `txNakReq` for one cycle, in the cycle after the token, and no data request.
- R5: For a non-isochronous endpoint (its `epIso` bit is 0), an intact ACK handshake (lower nibble 0010, byte 0xD2) after `txDone` has the following effect at the next edge: the endpoint's interrupt bit is set, its outcome code becomes 01 (success), and its buffer-full flag is cleared.
- R6: If no ACK has arrived when 18 `bitTick` pulses have been counted after `txDone`, the outcome code becomes 10 (timeout) at the edge of the 18th pulse. The buffer-full flag stays 1 and the interrupt bit is unchanged, so the next IN token resends the data. An ACK that arrives in the same cycle as the 18th pulse still counts as success.
- R7: For an isochronous endpoint, `txDone` alone sets the interrupt bit, writes outcome code 01 and clears the buffer-full flag at the next edge, with no handshake wait.
- R8: Interrupt bits stay set until written with a 1 on `intClrMask` while `intClrWe` is high. A set and a clear of the same bit in one cycle leave it set. `irq` is high whenever any interrupt bit is set.
- R9: `statRdData` shows the outcome code of `statRdEp` combinationally. A read with `statRdEn` clears that entry to 00 at the edge, unless an outcome is posted to the same endpoint in that cycle, in which case the posted code is kept.
- R10: `setFullWe` sets the buffer-full flag of `setFullEp`. A set and a hardware clear of the same flag in one cycle leave it set.
- R11: Tokens that arrive while a data transaction is open are ignored, and handshakes other than ACK do not end the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devAddr | input | 7 | Device address assigned to this function |
| epEnable | input | 16 | Per-endpoint enable |
| epIso | input | 16 | Per-endpoint isochronous type flag |
| tokValid | input | 1 | Decoded token pulse |
| tokPid | input | 8 | Token PID byte |
| tokAddr | input | 7 | Token device address |
| tokEp | input | 4 | Token endpoint number |
| bitTick | input | 1 | One pulse per full-speed bit time |
| txDone | input | 1 | Transmitter finished the data packet |
| hsValid | input | 1 | Received handshake pulse |
| hsPid | input | 8 | Handshake PID byte |
| txDataReq | output | 1 | Request to send the endpoint buffer |
| txNakReq | output | 1 | Request to send a NAK handshake |
| txEp | output | 4 | Endpoint for the transmit request |
| setFullWe | input | 1 | Microprocessor marks a buffer full |
| setFullEp | input | 4 | Endpoint for setFullWe |
| intClrWe | input | 1 | Write-one-to-clear strobe for interrupts |
| intClrMask | input | 16 | Interrupt bits to clear |
| statRdEn | input | 1 | Read-and-clear of an outcome code |
| statRdEp | input | 4 | Endpoint whose outcome code is shown |
| statRdData | output | 2 | Outcome code of statRdEp |
| bufFull | output | 16 | Buffer-full flags |
| intFlags | output | 16 | Interrupt bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardware posting an ACK result can collide in one cycle with microprocessor writes to the same endpoint. On endpoint 0, the bench drives the ACK together with a clear of that interrupt bit, a read-and-clear of that outcome code, and a set of that buffer flag. It then expects the interrupt bit to be 1, the code to be 01 and the flag to be 1. A second collision puts the ACK on the final bit-time pulse of the timeout window (endpoint 8). There, success is expected and no timeout code.

// File: rtl/in_xact_pkg.sv
package in_xact_pkg;

  // Lower-nibble token and handshake codes
  localparam logic [3:0] PID_IN  = 4'b1001;
  localparam logic [3:0] PID_ACK = 4'b0010;

  // Outcome codes kept per endpoint
  localparam logic [1:0] CODE_NONE    = 2'b00;
  localparam logic [1:0] CODE_OK      = 2'b01;
  localparam logic [1:0] CODE_TIMEOUT = 2'b10;

  // Strobes from the sequencer to the register bank
  typedef struct packed {
    logic       post;
    logic [1:0] code;
    logic       setInt;
    logic       clearFull;
  } post_strobe_t;

  function automatic logic pidIntact(input logic [7:0] pid);
    return pid[7:4] == ~pid[3:0];
  endfunction

endpackage

// File: rtl/in_xact_ctrl.sv
module in_xact_ctrl
  import in_xact_pkg::*;
#(
  parameter int NUM_EP       = 16,
  parameter int EP_W         = 4,
  parameter int ADDR_W       = 7,
  parameter int TIMEOUT_BITS = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [NUM_EP-1:0] epEnable,
  input  logic [NUM_EP-1:0] epIso,
  input  logic [NUM_EP-1:0] bufFull,
  input  logic              tokValid,
  input  logic [7:0]        tokPid,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              bitTick,
  input  logic              txDone,
  input  logic              hsValid,
  input  logic [7:0]        hsPid,
  output logic              txDataReq,
  output logic              txNakReq,
  output logic [EP_W-1:0]   txEp,
  output post_strobe_t      strobe
);

  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TIMEOUT_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT_HS} seq_e;

  seq_e            state;
  logic [EP_W-1:0] epQ;
  logic [CNT_W-1:0] tickCnt;
  logic            tokHit;
  logic            ackSeen;
  logic            timeUp;

  assign tokHit = tokValid && pidIntact(tokPid) && (tokPid[3:0] == PID_IN)
                  && (tokAddr == devAddr) && (int'(tokEp) < NUM_EP)
                  && epEnable[tokEp];
  assign ackSeen = hsValid && pidIntact(hsPid) && (hsPid[3:0] == PID_ACK);
  assign timeUp  = bitTick && (tickCnt == LAST_TICK);
  assign txEp    = epQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      epQ       <= '0;
      tickCnt   <= '0;
      txDataReq <= 1'b0;
      txNakReq  <= 1'b0;
    end else begin
      txDataReq <= 1'b0;
      txNakReq  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (tokHit) begin
            epQ <= tokEp;
            if (bufFull[tokEp]) begin
              txDataReq <= 1'b1;
              state     <= S_SEND;
            end else begin
              txNakReq <= 1'b1;
            end
          end
        end
        S_SEND: begin
          if (txDone) begin
            tickCnt <= '0;
            state   <= epIso[epQ] ? S_IDLE : S_WAIT_HS;
          end
        end
        S_WAIT_HS: begin
          if (ackSeen || timeUp) state <= S_IDLE;
          else if (bitTick)      tickCnt <= tickCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    unique case (state)
      S_SEND: begin
        if (txDone && epIso[epQ]) begin
          strobe.post      = 1'b1;
          strobe.code      = CODE_OK;
          strobe.setInt    = 1'b1;
          strobe.clearFull = 1'b1;
        end
      end
      S_WAIT_HS: begin
        if (ackSeen) begin
          strobe.post      = 1'b1;
          strobe.code      = CODE_OK;
          strobe.setInt    = 1'b1;
          strobe.clearFull = 1'b1;
        end else if (timeUp) begin
          strobe.post = 1'b1;
          strobe.code = CODE_TIMEOUT;
        end
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/in_xact_regs.sv
module in_xact_regs
  import in_xact_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  post_strobe_t      strobe,
  input  logic [EP_W-1:0]   postEp,
  input  logic              setFullWe,
  input  logic [EP_W-1:0]   setFullEp,
  input  logic              intClrWe,
  input  logic [NUM_EP-1:0] intClrMask,
  input  logic              statRdEn,
  input  logic [EP_W-1:0]   statRdEp,
  output logic [NUM_EP-1:0] bufFull,
  output logic [NUM_EP-1:0] intFlags,
  output logic [1:0]        statRdData
);

  logic [1:0] codeArr [NUM_EP];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic       fullR;
    logic       intR;
    logic [1:0] codeR;
    logic       hitPost;

    assign hitPost = strobe.post && (postEp == EP_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        fullR <= 1'b0;
        intR  <= 1'b0;
        codeR <= CODE_NONE;
      end else begin
        if (setFullWe && (setFullEp == EP_W'(e)))   fullR <= 1'b1;
        else if (hitPost && strobe.clearFull)       fullR <= 1'b0;

        if (hitPost && strobe.setInt)               intR <= 1'b1;
        else if (intClrWe && intClrMask[e])         intR <= 1'b0;

        if (hitPost)                                codeR <= strobe.code;
        else if (statRdEn && (statRdEp == EP_W'(e))) codeR <= CODE_NONE;
      end
    end

    assign bufFull[e]  = fullR;
    assign intFlags[e] = intR;
    assign codeArr[e]  = codeR;
  end

  assign statRdData = codeArr[statRdEp];

endmodule

// File: rtl/in_xact_engine.sv
module in_xact_engine
  import in_xact_pkg::*;
#(
  parameter int NUM_EP       = 16,
  parameter int ADDR_W       = 7,
  parameter int TIMEOUT_BITS = 18,
  localparam int EP_W        = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [NUM_EP-1:0] epEnable,
  input  logic [NUM_EP-1:0] epIso,
  input  logic              tokValid,
  input  logic [7:0]        tokPid,
  input  logic [ADDR_W-1:0] tokAddr,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              bitTick,
  input  logic              txDone,
  input  logic              hsValid,
  input  logic [7:0]        hsPid,
  output logic              txDataReq,
  output logic              txNakReq,
  output logic [EP_W-1:0]   txEp,
  input  logic              setFullWe,
  input  logic [EP_W-1:0]   setFullEp,
  input  logic              intClrWe,
  input  logic [NUM_EP-1:0] intClrMask,
  input  logic              statRdEn,
  input  logic [EP_W-1:0]   statRdEp,
  output logic [1:0]        statRdData,
  output logic [NUM_EP-1:0] bufFull,
  output logic [NUM_EP-1:0] intFlags,
  output logic              irq
);

  post_strobe_t postStrobe;

  in_xact_ctrl #(
    .NUM_EP(NUM_EP), .EP_W(EP_W), .ADDR_W(ADDR_W), .TIMEOUT_BITS(TIMEOUT_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .epEnable(epEnable),
    .epIso(epIso), .bufFull(bufFull), .tokValid(tokValid), .tokPid(tokPid),
    .tokAddr(tokAddr), .tokEp(tokEp), .bitTick(bitTick), .txDone(txDone),
    .hsValid(hsValid), .hsPid(hsPid), .txDataReq(txDataReq),
    .txNakReq(txNakReq), .txEp(txEp), .strobe(postStrobe)
  );

  in_xact_regs #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(postStrobe), .postEp(txEp),
    .setFullWe(setFullWe), .setFullEp(setFullEp), .intClrWe(intClrWe),
    .intClrMask(intClrMask), .statRdEn(statRdEn), .statRdEp(statRdEp),
    .bufFull(bufFull), .intFlags(intFlags), .statRdData(statRdData)
  );

  assign irq = |intFlags;

endmodule

// File: rtl/in_xact_chk.sv
module in_xact_chk #(
  parameter int NUM_EP = 16,
  parameter int EP_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tokValid,
  input logic              txDataReq,
  input logic              txNakReq,
  input logic [EP_W-1:0]   txEp,
  input logic [NUM_EP-1:0] bufFull,
  input logic [NUM_EP-1:0] intFlags,
  input logic              intClrWe,
  input logic              hsValid,
  input logic              txDone
);

  // R3
  one_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txDataReq && txNakReq));

  // R3
  data_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDataReq |-> ((($past(bufFull) >> txEp) & NUM_EP'(1)) != '0));

  // R4
  nak_needs_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    txNakReq |-> ((($past(bufFull) >> txEp) & NUM_EP'(1)) == '0));

  // R2
  reply_after_token_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txDataReq || txNakReq) |-> $past(tokValid));

  // R8
  int_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(intFlags) & ~intFlags)) |-> $past(intClrWe));

  // R5
  full_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(bufFull) & ~bufFull)) |-> $past(hsValid || txDone));

endmodule

bind in_xact_engine in_xact_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk(clk), .rstN(rstN), .tokValid(tokValid), .txDataReq(txDataReq),
  .txNakReq(txNakReq), .txEp(txEp), .bufFull(bufFull), .intFlags(intFlags),
  .intClrWe(intClrWe), .hsValid(hsValid), .txDone(txDone)
);

// File: tb/in_xact_engine_bench.sv
module in_xact_engine_bench;

  localparam logic [6:0] ADDR  = 7'h2A;
  localparam logic [7:0] P_IN  = 8'h69;
  localparam logic [7:0] P_ACK = 8'hD2;
  localparam logic [7:0] P_NAK = 8'h5A;

  logic clk = 1'b0;
  logic rstN;
  logic [6:0]  devAddr;
  logic [15:0] epEnable, epIso;
  logic tokValid; logic [7:0] tokPid; logic [6:0] tokAddr; logic [3:0] tokEp;
  logic bitTick, txDone, hsValid; logic [7:0] hsPid;
  logic txDataReq, txNakReq; logic [3:0] txEp;
  logic setFullWe; logic [3:0] setFullEp;
  logic intClrWe; logic [15:0] intClrMask;
  logic statRdEn; logic [3:0] statRdEp; logic [1:0] statRdData;
  logic [15:0] bufFull, intFlags; logic irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  in_xact_engine u_in_xact_engine (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .epEnable(epEnable), .epIso(epIso),
    .tokValid(tokValid), .tokPid(tokPid), .tokAddr(tokAddr), .tokEp(tokEp),
    .bitTick(bitTick), .txDone(txDone), .hsValid(hsValid), .hsPid(hsPid),
    .txDataReq(txDataReq), .txNakReq(txNakReq), .txEp(txEp),
    .setFullWe(setFullWe), .setFullEp(setFullEp), .intClrWe(intClrWe),
    .intClrMask(intClrMask), .statRdEn(statRdEn), .statRdEp(statRdEp),
    .statRdData(statRdData), .bufFull(bufFull), .intFlags(intFlags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sendTok(input logic [7:0] pid, input logic [6:0] addr, input int ep);
    tokPid = pid; tokAddr = addr; tokEp = 4'(ep); tokValid = 1'b1;
    step();
    tokValid = 1'b0;
  endtask

  task automatic peekCode(input int ep, input int exp, input string req);
    statRdEp = 4'(ep);
    #1;
    chk(statRdData == 2'(exp), req, statRdData, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; devAddr = ADDR; epEnable = 16'h7FFF; epIso = 16'h00F0;
    tokValid = 0; tokPid = 0; tokAddr = 0; tokEp = 0; bitTick = 1'b1;
    txDone = 0; hsValid = 0; hsPid = 0; setFullWe = 0; setFullEp = 0;
    intClrWe = 0; intClrMask = 0; statRdEn = 0; statRdEp = 0;
    repeat (3) step();
    // R1 reset state
    chk(bufFull == 0 && intFlags == 0 && !irq, "R1", {bufFull, intFlags}, 0);
    chk(!txDataReq && !txNakReq, "R1", {txDataReq, txNakReq}, 0);
    for (int ep = 0; ep < 16; ep++) peekCode(ep, 0, "R1");
    rstN = 1'b1;
    step();

    for (int ep = 0; ep < 16; ep++) begin
      logic en, iso;
      int k;
      en  = (ep != 15);
      iso = (ep >= 4 && ep <= 7);
      // R4 empty buffer answers NAK; disabled endpoint answers nothing (R2)
      sendTok(P_IN, ADDR, ep);
      chk(txNakReq == en && !txDataReq, en ? "R4" : "R2", {txDataReq, txNakReq}, {1'b0, en});
      // R10 processor marks buffer full
      setFullWe = 1'b1; setFullEp = 4'(ep);
      step();
      setFullWe = 1'b0;
      chk(bufFull[ep] == 1'b1, "R10", bufFull[ep], 1);
      if (!en) begin
        sendTok(P_IN, ADDR, ep);
        chk(!txDataReq && !txNakReq, "R2", {txDataReq, txNakReq}, 0);
        continue;
      end
      // R2 corrupted PID and foreign address
      sendTok(8'h99, ADDR, ep);
      chk(!txDataReq && !txNakReq, "R2", {txDataReq, txNakReq}, 0);
      sendTok(P_IN, ADDR ^ 7'h01, ep);
      chk(!txDataReq && !txNakReq, "R2", {txDataReq, txNakReq}, 0);
      // R3 data request
      sendTok(P_IN, ADDR, ep);
      chk(txDataReq && !txNakReq && txEp == 4'(ep), "R3", {txDataReq, txNakReq, txEp}, {2'b10, 4'(ep)});
      step();
      chk(!txDataReq, "R3", txDataReq, 0);
      // R11 token while transaction open
      sendTok(P_IN, ADDR, ep);
      chk(!txDataReq && !txNakReq, "R11", {txDataReq, txNakReq}, 0);
      txDone = 1'b1;
      step();
      txDone = 1'b0;
      if (iso) begin
        // R7 immediate posting
        chk(intFlags[ep] && !bufFull[ep], "R7", {intFlags[ep], bufFull[ep]}, 2'b10);
        peekCode(ep, 1, "R7");
      end else if (ep % 2 == 0) begin
        k = (ep == 8) ? 17 : ep;
        for (int i = 0; i < k; i++) begin
          if (i == 0) begin hsValid = 1'b1; hsPid = P_NAK; end
          step();
          hsValid = 1'b0;
        end
        chk(bufFull[ep] && !intFlags[ep], "R11", {bufFull[ep], intFlags[ep]}, 2'b10);
        peekCode(ep, 0, "R11");
        hsValid = 1'b1; hsPid = P_ACK;
        if (ep == 0) begin
          intClrWe = 1'b1; intClrMask = 16'h0001; statRdEn = 1'b1; statRdEp = 4'd0;
          setFullWe = 1'b1; setFullEp = 4'd0;
        end
        step();
        hsValid = 1'b0; intClrWe = 1'b0; statRdEn = 1'b0; setFullWe = 1'b0;
        chk(intFlags[ep], ep == 0 ? "R8" : "R5", intFlags[ep], 1);
        chk(bufFull[ep] == (ep == 0), ep == 0 ? "R10" : "R5", bufFull[ep], int'(ep == 0));
        peekCode(ep, 1, ep == 0 ? "R9" : (ep == 8 ? "R6" : "R5"));
      end else begin
        for (int i = 1; i <= 18; i++) begin
          step();
          if (i == 17) peekCode(ep, 0, "R6");
          if (i == 18) peekCode(ep, 2, "R6");
        end
        chk(bufFull[ep] && !intFlags[ep], "R6", {bufFull[ep], intFlags[ep]}, 2'b10);
        // R6 retained data is resent
        sendTok(P_IN, ADDR, ep);
        chk(txDataReq && txEp == 4'(ep), "R6", {txDataReq, txEp}, {1'b1, 4'(ep)});
        txDone = 1'b1;
        step();
        txDone = 1'b0; hsValid = 1'b1; hsPid = P_ACK;
        step();
        hsValid = 1'b0;
        chk(intFlags[ep] && !bufFull[ep], "R5", {intFlags[ep], bufFull[ep]}, 2'b10);
      end
      chk(irq, "R8", irq, 1);
      // R9 read shows code, then clears it
      statRdEp = 4'(ep); statRdEn = 1'b1;
      #1;
      chk(statRdData == 2'd1, "R9", statRdData, 1);
      step();
      statRdEn = 1'b0;
      peekCode(ep, 0, "R9");
      // R8 write-one-to-clear
      intClrWe = 1'b1; intClrMask = 16'(1 << ep);
      step();
      intClrWe = 1'b0;
      chk(intFlags == 0 && !irq, "R8", {intFlags, irq}, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule